// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block produces a single bus cycle on an 8-bit NAND flash interface. A cycle is either a command latch, an address latch, a data write or a data read. Each phase length is programmable and is counted in system clock cycles. The requester presents a cycle kind, a byte and a bank number while the block is idle. The block then walks through its phases, driving the latch enables, the write and read strobes, one chip enable per bank and the data output enable. When the cycle ends it pulses a done flag. On a read, the byte captured from the flash is held on a dedicated output.

Write-type cycles (command, address, data write) have three phases: setup, strobe and hold. A separate counter holds the data bus in tristate for a programmable number of cycles from the start of the access. A read cycle has no setup phase. Instead it waits a latch-to-read delay, and that delay depends on whether the most recent latch cycle was a command or an address. It then strobes the read enable and captures the byte on the final strobe cycle. All timing fields are sampled when the request is accepted.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset all chip enables, the write strobe and the read strobe are high, both latch enables are low, the data output enable is low, ready is high, done is low, and the stored bank number is 0.
- R2: A request is taken only on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low from the cycle after acceptance until the cycle in which done pulses. Requests presented while busy have no effect on the outputs.
- R3: Kind encoding is 0 command, 1 address, 2 data write, 3 data read. A write-type cycle starts with a setup phase of `cfg_tset_i`+1 cycles. During setup the write strobe is high, `cle_o` is high for a command, `ale_o` is high for an address, and both are low for a data write.
- R4: A write-type cycle drives `we_no` low for `cfg_twait_i`+1 cycles right after setup.
- R5: A hold phase of `cfg_thold_i`+1 cycles follows the strobe. Through the hold phase the strobe is high while the latch enable, the chip enable and the data bus keep their values.
- R6: In a write-type cycle `dq_oe_o` stays low for the first `cfg_thiz_i` cycles counted from the first setup cycle. It is then high until the end of hold; a value of 0 gives no tristate cycles. `dq_o` carries the request byte while enabled and is zero whenever `dq_oe_o` is low.
- R7: A read cycle first waits `cfg_tclr_i`+1 cycles if the latest command or address cycle was a command (or none has occurred since reset). It waits `cfg_tar_i`+1 cycles if that cycle was an address. Data cycles do not change this choice. Both latch enables stay low throughout a read.
- R8: A read cycle drives `re_no` low for `cfg_twait_i`+1 cycles and captures `dq_i` on the last low cycle into `rd_data_o`, which holds until the next read. `dq_oe_o` stays low during a read.
- R9: `done_o` is high for exactly one cycle, the first cycle after the hold phase. In that cycle all bus outputs are idle and `req_ready_o` is high.
- R10: During a cycle only `ce_no[b]` for the accepted bank number b is low; all chip enables are high when idle.
- R11: Timing fields changed after acceptance have no effect on the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_kind_i | input | 2 | Cycle kind: 0 cmd, 1 addr, 2 write, 3 read |
| req_data_i | input | 8 | Command, address or data byte |
| req_bank_i | input | 2 | Bank number |
| cfg_tclr_i | input | 4 | Command-latch to read delay minus one |
| cfg_tar_i | input | 4 | Address-latch to read delay minus one |
| cfg_thiz_i | input | 8 | Tristate cycles at start of a write-type cycle |
| cfg_thold_i | input | 8 | Hold length minus one |
| cfg_twait_i | input | 8 | Strobe length minus one |
| cfg_tset_i | input | 8 | Setup length minus one |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| ce_no | output | 4 | Per-bank chip enables, active low |
| dq_o | output | 8 | Data bus out |
| dq_oe_o | output | 1 | Data bus output enable |
| dq_i | input | 8 | Data bus in |
| rd_data_o | output | 8 | Byte captured by the last read |
| done_o | output | 1 | One-cycle end-of-cycle pulse |

## Verification
The bench compares every output against an arithmetic cycle model on every cycle of each access. It sweeps zero and non-zero values of each field, including the all-ones maximums, over all four kinds and banks. It targets the mixed encodings: a tristate count of zero must enable the bus in the first setup cycle, while a zero strobe, setup or hold must still last one cycle. A design that mixed these up shifts every edge by one cycle. Reads are issued after commands, after addresses and after data writes. Picking the wrong latch-to-read delay, or capturing on the wrong strobe cycle, shows up as a shifted strobe or a wrong byte, because the bench changes `dq_i` on every cycle. The bench also scrambles the timing fields right after acceptance and holds `req_valid_i` high through busy cycles. A design that samples fields late, or takes requests while busy, distorts the waveform.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_WR   = 2'd2,
    KIND_RD   = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_DELAY  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  function automatic logic is_write_kind(kind_e k);
    return k != KIND_RD;
  endfunction

endpackage

// File: rtl/nand_phase_ctrl.sv
module nand_phase_ctrl
  import nand_seq_pkg::*;
#(
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  kind_e              req_kind_i,
  input  logic [SHORT_W-1:0] cfg_tclr_i,
  input  logic [SHORT_W-1:0] cfg_tar_i,
  input  logic [LONG_W-1:0]  cfg_twait_i,
  input  logic [LONG_W-1:0]  cfg_thold_i,
  input  logic [LONG_W-1:0]  cfg_tset_i,
  output logic               accept_o,
  output phase_e             phase_o,
  output kind_e              kind_o,
  output logic               done_o,
  output logic               capture_o
);

  phase_e             phase_q;
  kind_e              kind_q;
  logic [LONG_W-1:0]  cnt_q;
  logic [LONG_W-1:0]  twait_q;
  logic [LONG_W-1:0]  thold_q;
  logic               last_cle_q;
  logic               done_q;
  logic               cnt_zero;
  logic               accept;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = req_valid_i && (phase_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      kind_q     <= KIND_CMD;
      cnt_q      <= '0;
      twait_q    <= '0;
      thold_q    <= '0;
      last_cle_q <= 1'b1;
      done_q     <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_HOLD) && cnt_zero;
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            kind_q  <= req_kind_i;
            twait_q <= cfg_twait_i;
            thold_q <= cfg_thold_i;
            if (req_kind_i == KIND_RD) begin
              phase_q <= PH_DELAY;
              cnt_q   <= last_cle_q ? LONG_W'(cfg_tclr_i) : LONG_W'(cfg_tar_i);
            end else begin
              phase_q <= PH_SETUP;
              cnt_q   <= cfg_tset_i;
            end
            if (req_kind_i == KIND_CMD) last_cle_q <= 1'b1;
            else if (req_kind_i == KIND_ADDR) last_cle_q <= 1'b0;
          end
        end
        PH_SETUP, PH_DELAY: begin
          if (cnt_zero) begin
            phase_q <= PH_STROBE;
            cnt_q   <= twait_q;
          end else begin
            cnt_q <= cnt_q - LONG_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt_zero) begin
            phase_q <= PH_HOLD;
            cnt_q   <= thold_q;
          end else begin
            cnt_q <= cnt_q - LONG_W'(1);
          end
        end
        PH_HOLD: begin
          if (cnt_zero) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - LONG_W'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign accept_o  = accept;
  assign phase_o   = phase_q;
  assign kind_o    = kind_q;
  assign done_o    = done_q;
  assign capture_o = (phase_q == PH_STROBE) && cnt_zero && (kind_q == KIND_RD);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_after_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(phase_q) == PH_HOLD);

  assert_busy_kind_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |=> $stable(kind_q));

  assert_read_no_setup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == KIND_RD) |-> (phase_q != PH_SETUP));

  assert_write_no_delay_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q != KIND_RD) |-> (phase_q != PH_DELAY));

endmodule

// File: rtl/nand_hiz_timer.sv
module nand_hiz_timer #(
  parameter int LONG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [LONG_W-1:0] thiz_i,
  input  logic              wr_busy_i,
  output logic              oe_o
);

  logic [LONG_W-1:0] hiz_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hiz_q <= '0;
    end else if (accept_i) begin
      hiz_q <= thiz_i;
    end else if (hiz_q != '0) begin
      hiz_q <= hiz_q - LONG_W'(1);
    end
  end

  assign oe_o = wr_busy_i && (hiz_q == '0);

  assert_hiz_countdown_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiz_q != '0 && !accept_i) |=> (hiz_q == $past(hiz_q) - LONG_W'(1)));

endmodule

// File: rtl/nand_bank_dec.sv
module nand_bank_dec #(
  parameter int NBANK = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [BW-1:0]    bank_i,
  input  logic             active_i,
  output logic [NBANK-1:0] ce_no
);

  logic [BW-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= '0;
    else if (accept_i) bank_q <= bank_i;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_ce
    assign ce_no[b] = !(active_i && (bank_q == BW'(b)));
  end

  assert_ce_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ce_no));

  assert_ce_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (&ce_no));

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_seq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NBANK   = 4,
  parameter int SHORT_W = 4,
  parameter int LONG_W  = 8,
  localparam int BW     = $clog2(NBANK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [1:0]         req_kind_i,
  input  logic [DW-1:0]      req_data_i,
  input  logic [BW-1:0]      req_bank_i,
  input  logic [SHORT_W-1:0] cfg_tclr_i,
  input  logic [SHORT_W-1:0] cfg_tar_i,
  input  logic [LONG_W-1:0]  cfg_thiz_i,
  input  logic [LONG_W-1:0]  cfg_thold_i,
  input  logic [LONG_W-1:0]  cfg_twait_i,
  input  logic [LONG_W-1:0]  cfg_tset_i,
  output logic               cle_o,
  output logic               ale_o,
  output logic               we_no,
  output logic               re_no,
  output logic [NBANK-1:0]   ce_no,
  output logic [DW-1:0]      dq_o,
  output logic               dq_oe_o,
  input  logic [DW-1:0]      dq_i,
  output logic [DW-1:0]      rd_data_o,
  output logic               done_o
);

  logic          accept;
  phase_e        phase;
  kind_e         kind;
  logic          capture;
  logic          active;
  logic          wr_busy;
  logic          oe;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  nand_phase_ctrl #(
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_kind_i  (kind_e'(req_kind_i)),
    .cfg_tclr_i  (cfg_tclr_i),
    .cfg_tar_i   (cfg_tar_i),
    .cfg_twait_i (cfg_twait_i),
    .cfg_thold_i (cfg_thold_i),
    .cfg_tset_i  (cfg_tset_i),
    .accept_o    (accept),
    .phase_o     (phase),
    .kind_o      (kind),
    .done_o      (done_o),
    .capture_o   (capture)
  );

  assign active  = (phase != PH_IDLE);
  assign wr_busy = active && is_write_kind(kind);

  nand_hiz_timer #(
    .LONG_W (LONG_W)
  ) u_hiz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .thiz_i    (cfg_thiz_i),
    .wr_busy_i (wr_busy),
    .oe_o      (oe)
  );

  nand_bank_dec #(
    .NBANK (NBANK)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .bank_i   (req_bank_i),
    .active_i (active),
    .ce_no    (ce_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) wdata_q <= req_data_i;
      if (capture) rdata_q <= dq_i;
    end
  end

  assign req_ready_o = (phase == PH_IDLE);
  assign cle_o       = active && (kind == KIND_CMD);
  assign ale_o       = active && (kind == KIND_ADDR);
  assign we_no       = !((phase == PH_STROBE) && is_write_kind(kind));
  assign re_no       = !((phase == PH_STROBE) && (kind == KIND_RD));
  assign dq_oe_o     = oe;
  assign dq_o        = oe ? wdata_q : '0;
  assign rd_data_o   = rdata_q;

  assert_strobe_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));

  assert_latch_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));

  assert_no_drive_on_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !dq_oe_o);

  assert_strobe_has_ce_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |-> !(&ce_no));

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (req_ready_o && we_no && re_no && !dq_oe_o && (&ce_no)));

  assert_rdata_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_no && $past(re_no)) |-> $stable(rd_data_o));

endmodule

// File: tb/nand_cycle_seq_tb_top.sv
module nand_cycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [7:0] req_data = 8'd0;
  logic [1:0] req_bank = 2'd0;
  logic [3:0] tclr = 4'd0, tar = 4'd0;
  logic [7:0] thiz = 8'd0, thold = 8'd0, twait = 8'd0, tset = 8'd0;
  logic       cle, ale, we_n, re_n, oe, done;
  logic [3:0] ce_n;
  logic [7:0] dq_out, dq_in = 8'd0, rd_data;

  int checks = 0;
  int errors = 0;
  bit last_cle = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cycle_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_data_i(req_data), .req_bank_i(req_bank),
    .cfg_tclr_i(tclr), .cfg_tar_i(tar), .cfg_thiz_i(thiz),
    .cfg_thold_i(thold), .cfg_twait_i(twait), .cfg_tset_i(tset),
    .cle_o(cle), .ale_o(ale), .we_no(we_n), .re_no(re_n), .ce_no(ce_n),
    .dq_o(dq_out), .dq_oe_o(oe), .dq_i(dq_in), .rd_data_o(rd_data), .done_o(done)
  );

  function automatic logic [18:0] actual_vec();
    return {req_ready, done, cle, ale, we_n, re_n, ce_n, oe, dq_out};
  endfunction

  task automatic check_vec(string tag, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b (rdy done cle ale we re ce4 oe dq8)", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bus_byte(logic [7:0] seed, int i);
    return seed ^ 8'h5A ^ 8'(i * 7);
  endfunction

  // One access; bench model of every output per cycle.
  task automatic run_op(int kind, logic [7:0] data, int bank,
                        int s, int w, int h, int z, int cl, int ar, bit poke);
    int first, strobe_end, total, cap_i;
    bit is_rd;
    logic [18:0] exp;
    logic [3:0] ce_act;
    string tag;
    is_rd = (kind == 3);
    @(negedge clk);
    req_kind = 2'(kind); req_data = data; req_bank = 2'(bank);
    tset = 8'(s); twait = 8'(w); thold = 8'(h); thiz = 8'(z);
    tclr = 4'(cl); tar = 4'(ar);
    req_valid = 1'b1;
    @(posedge clk);
    first = is_rd ? ((last_cle ? cl : ar) + 1) : (s + 1);
    strobe_end = first + w + 1;
    total = strobe_end + h + 1;
    cap_i = strobe_end - 1;
    ce_act = ~(4'b0001 << bank);
    for (int i = 0; i <= total + 1; i++) begin
      @(negedge clk);
      if (i < total) begin
        exp[18] = 1'b0; exp[17] = 1'b0;
        exp[16] = (kind == 0);
        exp[15] = (kind == 1);
        exp[14] = !(!is_rd && i >= first && i < strobe_end);
        exp[13] = !(is_rd && i >= first && i < strobe_end);
        exp[12:9] = ce_act;
        exp[8] = !is_rd && (i >= z);
        exp[7:0] = exp[8] ? data : 8'h00;
        if (i < first) tag = is_rd ? "R7 R10 R11" : "R3 R6 R10 R11";
        else if (i < strobe_end) tag = is_rd ? "R8 R10 R11" : "R4 R6 R10 R11";
        else tag = "R5 R6 R10 R11";
        if (poke) tag = {tag, " R2"};
      end else begin
        exp = {1'b1, (i == total), 2'b00, 2'b11, 4'hF, 1'b0, 8'h00};
        tag = (i == total) ? "R9" : "R9 R2";
      end
      check_vec(tag, actual_vec(), exp);
      if (i == total && is_rd) begin
        checks++;
        if (rd_data !== bus_byte(data, cap_i)) begin
          errors++;
          $display("FAIL R8 capture: actual %h expected %h", rd_data, bus_byte(data, cap_i));
        end
      end
      dq_in = bus_byte(data, i);
      if (i == 0) begin
        // R11: scramble timing after acceptance
        tset = ~tset; twait = ~twait; thold = ~thold; thiz = ~thiz;
        tclr = ~tclr; tar = ~tar;
        if (poke) begin req_kind = ~req_kind; req_bank = ~req_bank; req_data = ~req_data; end
        else req_valid = 1'b0;
      end
      if (i == total) req_valid = 1'b0;
    end
    if (kind == 0) last_cle = 1'b1;
    else if (kind == 1) last_cle = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1: reset state
    check_vec("R1", actual_vec(), {1'b1, 1'b0, 2'b00, 2'b11, 4'hF, 1'b0, 8'h00});
    checks++;
    if (rd_data !== 8'h00) begin
      errors++;
      $display("FAIL R1 rd_data: actual %h expected 00", rd_data);
    end
    rst_n = 1'b1;
    // R7: read right after reset uses command delay; R1 bank 0 default not changed by request
    run_op(3, 8'hC3, 0, 1, 1, 1, 0, 2, 9, 1'b0);
    for (int idx = 0; idx < 16; idx++) begin
      int s, w, h, z, cl, ar, b;
      s  = (idx % 2) * 2;
      w  = (idx / 2) % 2;
      h  = ((idx / 4) % 2) * 3;
      z  = (idx * 5) % 13;
      cl = (idx % 4) ^ 1;
      ar = (idx + 2) % 7;
      b  = idx % 4;
      run_op(0, 8'(idx * 17 + 1), b, s, w, h, z, cl, ar, idx[0]);
      run_op(3, 8'(idx * 3 + 2), (b + 1) % 4, s, w, h, z, cl, ar, 1'b0);
      run_op(1, 8'(idx * 29 + 5), (b + 2) % 4, s, w, h, z, cl, ar, idx[1]);
      run_op(3, 8'(idx * 11 + 7), (b + 3) % 4, s, w, h, z, cl, ar, idx[2]);
      run_op(2, 8'(idx * 13 + 9), b, s, w, h, z, cl, ar, 1'b0);
      run_op(3, 8'(idx * 7 + 3), b, s, w, h, z, cl, ar, 1'b0);
    end
    // extremes: all-ones fields, tristate outlasting the access
    run_op(0, 8'hFF, 3, 255, 255, 255, 255, 15, 15, 1'b0);
    run_op(3, 8'h81, 2, 255, 255, 255, 255, 15, 15, 1'b0);
    run_op(1, 8'h42, 1, 255, 255, 255, 200, 15, 15, 1'b1);
    run_op(3, 8'h24, 0, 0, 0, 0, 0, 15, 15, 1'b0);
    run_op(2, 8'h99, 1, 0, 0, 0, 3, 0, 0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule